// File: doc/BRIEF.md
# Sinc-Cubed Decimator with Synchronize and Settling Gate

This block turns the one-bit output stream of a delta-sigma modulator into 16-bit unipolar words. Each accepted modulator bit counts as 1 or 0 and passes through a third-order sinc filter. The filter has three running integrators that run at the sample rate and three differencing stages that run at the word rate. A two-bit rate code picks how many samples make one word. The notches move with the rate code, but the shape of the response stays the same. The word rate is the first notch. The sample strobe may arrive at any spacing. The usual spacing is one sample every 128 master clocks.

A synchronize pulse clears the whole filter and the sample counter. Loading a new rate code clears them in the same way. After a clear, the block withholds the first two words, because those words still carry history from before the clear. The first word it marks ready is the third one, which is a settled result. A ready word is announced by a one-cycle pulse, and the word stays on the output until the next pulse. A step in the input that is not synchronized can need a fourth word before the output settles. No logic handles that case: the system simply waits longer.

Top module: `sinc_decimator`

## Requirements
- R1: The rate code sets the number of accepted samples per word: code 0 gives 384, code 1 gives 320, code 2 gives 96 and code 3 gives 48. After a clear, ready pulses come on the 3R-th accepted sample and then on every R-th accepted sample after it.
- R2: A sample bit of 1 adds one and a bit of 0 adds nothing. Take a settled input whose ones density is 1/P, where P divides R. The word then equals (R^3/P) shifted right by 10, 9, 4 or 1 bits for codes 0, 1, 2 and 3. A full-scale input therefore gives 55296, 64000, 55296 and 55296.
- R3: After a synchronize pulse, the first two words are withheld. The first ready pulse comes exactly on the 3R-th accepted sample.
- R4: The ready output is a single-cycle pulse and is low in the cycle after any pulse.
- R5: The output word changes only in a cycle where the ready pulse is high. Between pulses it holds its value.
- R6: A synchronize pulse clears the integrators, the differencing stages and the sample counter. An all-zero input after a synchronize gives a first ready word of 0, even when the input before it was full scale.
- R7: Any change of the rate code acts as a synchronize, with no synchronize pulse needed. The first ready pulse then comes on the 3R-th sample of the new rate and carries the settled value for that rate.
- R8: Take an unsynchronized step from all zeros to all ones that lands in the middle of a word period. The third word after the step is not yet full scale, and the fourth word is full scale.
- R9: While reset is high and directly after it, the output word is 0 and the ready output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_bit | input | 1 | Modulator output bit |
| mod_stb | input | 1 | One-cycle strobe marking a valid modulator bit |
| rate_sel | input | 2 | Rate code that chooses the decimation ratio |
| sync | input | 1 | Synchronize pulse that clears the filter state |
| dout | output | 16 | Last settled output word |
| drdy | output | 1 | One-cycle pulse marking a new settled word |

## Verification
The main corner is the position of the first ready pulse after a clear. A settling counter that is off by one word would pulse on sample 2R or 4R instead of 3R, or would let out a partial word that falls below the full-scale value. A clear that misses any integrator or differencing register leaves a constant residue in the filter. Zeros fed after a full-scale history would then give a nonzero word. A rate change that does not act as a clear shows up as a ready pulse that comes early with a mixed-rate value. The mid-period step exposes a gate that counts words in a way that hides the fourth-word settling.

// File: rtl/sinc_decimator_pkg.sv
package sinc_decimator_pkg;

  typedef logic [1:0] rate_code_t;

  // Cube of a decimation ratio, i.e. the full-scale filter gain.
  function automatic longint ratio_cube(input longint r);
    return r * r * r;
  endfunction

  // Smallest right shift that squeezes full scale into w unsigned bits.
  function automatic int fit_shift(input longint full, input int w);
    int s;
    s = 0;
    while ((full >> s) >= (longint'(1) << w)) s++;
    return s;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sinc_dec_seq.sv
module sinc_dec_seq
  import sinc_decimator_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  rate_code_t       rate_sel,
  input  logic             sync,
  input  logic             mod_stb,
  input  logic [CNT_W-1:0] ratio_m1,
  output rate_code_t       sel_q,
  output logic             clr,
  output logic             samp,
  output logic             tick,
  output logic             tick_ok
);

  localparam int SETTLE_WORDS = 3;
  localparam int WC_W = $clog2(SETTLE_WORDS);

  logic [CNT_W-1:0] cnt;
  logic [WC_W-1:0]  wcnt;

  // Explicit pulse or a newly loaded rate code both clear the filter.
  assign clr     = sync | (rate_sel != sel_q);
  assign samp    = mod_stb & ~clr;
  assign tick    = samp & (cnt == ratio_m1);
  assign tick_ok = tick & (wcnt == WC_W'(SETTLE_WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= rate_sel;
      cnt   <= '0;
      wcnt  <= '0;
    end else begin
      sel_q <= rate_sel;
      if (clr) begin
        cnt  <= '0;
        wcnt <= '0;
      end else if (samp) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick && wcnt != WC_W'(SETTLE_WORDS - 1)) wcnt <= wcnt + 1'b1;
      end
    end
  end

  // R4: decimation points never fall on adjacent cycles (ratio >= 2)
  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R3: a clear withholds readiness on the following cycle
  p_clear_gates_r3: assert property (@(posedge clk) disable iff (rst)
    clr |=> !tick_ok);

endmodule

// File: rtl/sinc_dec_integ.sv
module sinc_dec_integ #(
  parameter int ACC_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             samp,
  input  logic             mod_bit,
  output logic [ACC_W-1:0] i3_next
);

  localparam int STAGES = 3;

  logic [ACC_W-1:0] acc   [STAGES];
  logic [ACC_W-1:0] acc_n [STAGES];

  // Chained within a cycle: every stage sees the new value of the one before.
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign acc_n[g] = acc[g] + ACC_W'(mod_bit);
      end else begin : g_rest
        assign acc_n[g] = acc[g] + acc_n[g-1];
      end

      always_ff @(posedge clk) begin
        if (rst || clr)  acc[g] <= '0;
        else if (samp)   acc[g] <= acc_n[g];
      end
    end
  endgenerate

  assign i3_next = acc_n[STAGES-1];

endmodule

// File: rtl/sinc_dec_comb.sv
module sinc_dec_comb #(
  parameter int ACC_W  = 28,
  parameter int DOUT_W = 16,
  parameter int SH_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tick,
  input  logic              tick_ok,
  input  logic [ACC_W-1:0]  i3_next,
  input  logic [SH_W-1:0]   shift,
  input  logic [ACC_W-1:0]  r_cube,
  output logic [DOUT_W-1:0] word,
  output logic              word_rdy
);

  logic [ACC_W-1:0] d1, d2, d3;
  logic [ACC_W-1:0] c1, c2, c3;

  assign c1 = i3_next - d1;
  assign c2 = c1 - d2;
  assign c3 = c2 - d3;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      d1 <= '0;
      d2 <= '0;
      d3 <= '0;
    end else if (tick) begin
      d1 <= i3_next;
      d2 <= c1;
      d3 <= c2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word     <= '0;
      word_rdy <= 1'b0;
    end else begin
      word_rdy <= tick_ok;
      if (tick_ok) word <= DOUT_W'(c3 >> shift);
    end
  end

  // R2: a unipolar sinc-cubed result never exceeds the ratio cubed
  p_cic_bound_r2: assert property (@(posedge clk) disable iff (rst)
    tick |-> (c3 <= r_cube));

  // R4: ready is a single-cycle pulse
  p_rdy_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    word_rdy |=> !word_rdy);

endmodule

// File: rtl/sinc_decimator.sv
module sinc_decimator
  import sinc_decimator_pkg::*;
#(
  parameter int DOUT_W = 16,
  parameter int RATIO0 = 384,
  parameter int RATIO1 = 320,
  parameter int RATIO2 = 96,
  parameter int RATIO3 = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mod_bit,
  input  logic              mod_stb,
  input  logic [1:0]        rate_sel,
  input  logic              sync,
  output logic [DOUT_W-1:0] dout,
  output logic              drdy
);

  localparam int R_MAX = max4(RATIO0, RATIO1, RATIO2, RATIO3);
  localparam int CNT_W = $clog2(R_MAX);
  localparam int ACC_W = 3 * $clog2(R_MAX) + 1;
  localparam int SH_W  = 6;

  localparam int     RATIO [4] = '{RATIO0, RATIO1, RATIO2, RATIO3};
  localparam longint CUBE  [4] = '{ratio_cube(RATIO0), ratio_cube(RATIO1),
                                   ratio_cube(RATIO2), ratio_cube(RATIO3)};
  localparam int     SHIFT [4] = '{fit_shift(CUBE[0], DOUT_W), fit_shift(CUBE[1], DOUT_W),
                                   fit_shift(CUBE[2], DOUT_W), fit_shift(CUBE[3], DOUT_W)};

  rate_code_t       sel_q;
  logic             clr, samp, tick, tick_ok;
  logic [CNT_W-1:0] ratio_m1;
  logic [ACC_W-1:0] i3_next, r_cube;
  logic [SH_W-1:0]  shift;

  assign ratio_m1 = CNT_W'(RATIO[sel_q] - 1);
  assign r_cube   = ACC_W'(CUBE[sel_q]);
  assign shift    = SH_W'(SHIFT[sel_q]);

  sinc_dec_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .sync(sync), .mod_stb(mod_stb),
    .ratio_m1(ratio_m1), .sel_q(sel_q), .clr(clr), .samp(samp),
    .tick(tick), .tick_ok(tick_ok)
  );

  sinc_dec_integ #(.ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst(rst), .clr(clr), .samp(samp), .mod_bit(mod_bit),
    .i3_next(i3_next)
  );

  sinc_dec_comb #(.ACC_W(ACC_W), .DOUT_W(DOUT_W), .SH_W(SH_W)) u_comb (
    .clk(clk), .rst(rst), .clr(clr), .tick(tick), .tick_ok(tick_ok),
    .i3_next(i3_next), .shift(shift), .r_cube(r_cube),
    .word(dout), .word_rdy(drdy)
  );

  // R5: the word only moves together with a ready pulse
  p_dout_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !drdy |-> $stable(dout));

  // R3: no ready pulse directly after a synchronize
  p_sync_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    sync |=> !drdy);

  // R7: a rate-code change suppresses readiness like a synchronize
  p_rate_sync_r7: assert property (@(posedge clk) disable iff (rst)
    (rate_sel != sel_q) |=> !drdy);

endmodule

// File: tb/sim_sinc_decimator.sv
module sim_sinc_decimator;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mod_bit = 1'b0;
  logic        mod_stb = 1'b0;
  logic [1:0]  rate_sel = 2'd0;
  logic        sync = 1'b0;
  logic [15:0] dout;
  logic        drdy;

  int total = 0;
  int bad = 0;
  int pulse_err = 0;
  int hold_err = 0;
  logic [15:0] last_dout = '0;
  logic got;

  always #5 clk = ~clk;

  sinc_decimator u0 (
    .clk(clk), .rst(rst), .mod_bit(mod_bit), .mod_stb(mod_stb),
    .rate_sel(rate_sel), .sync(sync), .dout(dout), .drdy(drdy)
  );

  // Vector: [23:22] rate code, [21:18] ones period (0 = all zeros), [17:0] settled word
  localparam logic [23:0] VEC [10] = '{
    {2'd0, 4'd1, 18'd55296},  // R2 full scale, ratio 384
    {2'd1, 4'd1, 18'd64000},  // R2 full scale, ratio 320
    {2'd2, 4'd1, 18'd55296},  // R2 full scale, ratio 96
    {2'd3, 4'd1, 18'd55296},  // R2 full scale, ratio 48
    {2'd0, 4'd4, 18'd13824},  // R2 quarter density
    {2'd1, 4'd4, 18'd16000},
    {2'd2, 4'd4, 18'd13824},
    {2'd3, 4'd4, 18'd13824},
    {2'd1, 4'd0, 18'd0},      // R2 all zeros
    {2'd3, 4'd2, 18'd27648}   // R2 half density
  };

  function automatic int ratio_of(input logic [1:0] s);
    case (s)
      2'd0: return 384;
      2'd1: return 320;
      2'd2: return 96;
      default: return 48;
    endcase
  endfunction

  function automatic logic pat(input int per, input int idx);
    if (per == 0) return 1'b0;
    return (idx % per) == 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic watch_hold();
    if (!drdy && dout != last_dout) hold_err++;
    last_dout = dout;
  endtask

  // One accepted sample; the strobe is high for one edge, low for the next.
  task automatic send(input logic b);
    mod_bit = b;
    mod_stb = 1'b1;
    @(negedge clk);
    got = drdy;
    watch_hold();
    mod_stb = 1'b0;
    @(negedge clk);
    if (drdy) pulse_err++;
    watch_hold();
  endtask

  task automatic do_sync();
    sync = 1'b1;
    @(negedge clk);
    watch_hold();
    sync = 1'b0;
  endtask

  task automatic set_sel(input logic [1:0] s);
    rate_sel = s;
    @(negedge clk);
    watch_hold();
  endtask

  task automatic run_vec(input logic [1:0] s, input int per, input int exp);
    int r;
    int first, second, v1, v2;
    r = ratio_of(s);
    first = -1; second = -1; v1 = -1; v2 = -1;
    set_sel(s);
    do_sync();
    for (int n = 1; n <= 4 * r; n++) begin
      send(pat(per, n - 1));
      if (got) begin
        if (first < 0) begin first = n; v1 = int'(dout); end
        else if (second < 0) begin second = n; v2 = int'(dout); end
      end
    end
    check("R3 first ready sample", first, 3 * r);
    check("R1 second ready sample", second, 4 * r);
    check("R2 first settled word", v1, exp);
    check("R2 second settled word", v2, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r, first, v, k, w3, w4;
    repeat (3) @(negedge clk);
    check("R9 dout in reset", int'(dout), 0);
    check("R9 drdy in reset", int'(drdy), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 dout after reset", int'(dout), 0);
    check("R9 drdy after reset", int'(drdy), 0);
    last_dout = dout;

    for (int i = 0; i < 10; i++)
      run_vec(VEC[i][23:22], int'(VEC[i][21:18]), int'(VEC[i][17:0]));

    // R6: full-scale history, then sync and zeros
    set_sel(2'd3);
    do_sync();
    r = 48;
    for (int n = 0; n < 4 * r; n++) send(1'b1);
    do_sync();
    first = -1; v = -1;
    for (int n = 1; n <= 3 * r; n++) begin
      send(1'b0);
      if (got && first < 0) begin first = n; v = int'(dout); end
    end
    check("R3 ready after sync", first, 3 * r);
    check("R6 cleared history word", v, 0);

    // R7: rate change mid-stream without a sync pulse
    for (int n = 0; n < 30; n++) send(1'b1);
    set_sel(2'd2);
    r = 96;
    first = -1; v = -1;
    for (int n = 1; n <= 4 * r; n++) begin
      send(1'b1);
      if (got && first < 0) begin first = n; v = int'(dout); end
    end
    check("R7 ready after rate change", first, 3 * r);
    check("R7 settled word after rate change", v, 55296);

    // R8: unsynchronized step in the middle of a word period
    set_sel(2'd3);
    do_sync();
    r = 48;
    for (int n = 0; n < 4 * r + 24; n++) send(1'b0);
    k = 0; w3 = -1; w4 = -1;
    for (int n = 0; n < 5 * r; n++) begin
      send(1'b1);
      if (got) begin
        k++;
        if (k == 3) w3 = int'(dout);
        if (k == 4) w4 = int'(dout);
      end
    end
    check("R8 third word not settled", int'(w3 != 55296), 1);
    check("R8 fourth word settled", w4, 55296);

    check("R4 single-cycle ready", pulse_err, 0);
    check("R5 word held between pulses", hold_err, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule